// File: doc/BRIEF.md
# Decoupled Load/Store Data Queue Unit

This unit separates sending a memory address from using the data behind it. A load address goes to the memory port in the same cycle it is presented, provided there is room. The memory returns read data in request order, after one or more cycles. That data collects in an in-order load queue. The consumer takes data from the queue by reading a reserved register, and the queue pops its oldest entry at that point.

Stores are split the same way. The producer writes store data into a data queue by writing a reserved register. Store addresses arrive on their own port at any time. A write request goes out only when both an address and a data word are waiting.

A load address is held off once the loads in flight plus the words already queued reach the load queue capacity. A read of an empty queue stalls the consumer. Stalls that no later event can resolve raise a sticky trap.

Top module: `ldst_queue_unit`

## Requirements
- R1: After reset every stall output, `memReqValid` and `trap` are low while all request inputs are low.
- R2: A load address that has a free slot appears on the memory port in the same cycle as a read (`memReqValid`=1, `memReqWrite`=0, `memReqAddr`=`ldAddr`), and `ldAddrStall` stays low when `memReqReady` is high.
- R3: The loads accepted but not yet answered, plus the words in the load queue, never exceed LD_DEPTH (4). A load address that would exceed it raises `ldAddrStall` and is not sent.
- R4: `popData` returns read data in the order the load addresses were accepted.
- R5: `popReq` on an empty load queue raises `popStall` and removes nothing. `popReq` on a non-empty queue does not stall and pops the head.
- R6: The store data queue holds ST_DEPTH (4) words. `pushReq` while it is full raises `pushStall` and writes nothing.
- R7: A write request (`memReqWrite`=1) is raised only when both store queues are non-empty. It carries the oldest store address and the oldest store data, each in FIFO order.
- R8: When a load and a store are both ready, the load gets the memory port. The write waits with its queues unchanged.
- R9: `popReq` on an empty load queue, with no load outstanding and none accepted in that cycle, sets `trap` from the next cycle.
- R10: `pushReq` on a full store data queue, with the address queue empty and `stAddrValid` low, sets `trap` from the next cycle. Once set, `trap` stays high until reset.
- R11: A response that arrives in the same cycle as a pop is queued, and no data is lost or duplicated.
- R12: The store address queue holds ST_DEPTH (4) addresses. `stAddrValid` while it is full raises `stAddrStall` and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldAddrValid | input | 1 | Load address presented |
| ldAddr | input | AW | Load address |
| ldAddrStall | output | 1 | Load address not taken this cycle |
| stAddrValid | input | 1 | Store address presented |
| stAddr | input | AW | Store address |
| stAddrStall | output | 1 | Store address queue full |
| popReq | input | 1 | Read of the load data register |
| popData | output | DW | Oldest load data |
| popStall | output | 1 | Load queue empty, read must wait |
| pushReq | input | 1 | Write of the store data register |
| pushData | input | DW | Store data |
| pushStall | output | 1 | Store data queue full |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | AW | Request address |
| memReqData | output | DW | Write data (zero on reads) |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data returning, in request order |
| memRspData | input | DW | Returned read data |
| trap | output | 1 | Sticky deadlock indication |

## Verification
The hardest state to reach is a full load window: four loads issued, a slow response stream, and pops that arrive seldom. Only then does the fifth address stall, and only then can a pop and a response land in the same cycle with the queue near capacity. The stimulus runs phases with biased probabilities to get there. One phase favours load issue over pops and returns responses late. Other phases starve the store address or store data side so that each store queue fills. Both deadlock traps are set by directed sequences after a full drain, and each is followed by a reset to show the trap clears.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
package ldst_pkg;
  // Strobes from the control module to the queue datapath
  typedef struct packed {
    logic ldPush;     // returning read data enters load queue
    logic ldPop;      // consumer takes load head
    logic sdPush;     // store data enters its queue
    logic sdPop;      // store data head leaves with a write
    logic saPush;     // store address enters its queue
    logic saPop;      // store address head leaves with a write
    logic issueStore; // memory port carries the store heads
  } qStrobe_t;
endpackage

// File: rtl/ldst_fifo.sv
`timescale 1ns/1ps
module ldst_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic          doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  generate
    if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_wrap
      assign wrNext = (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrNext;
      if (doPop)  rdPtr <= rdNext;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ldst_datapath.sv
`timescale 1ns/1ps
module ldst_datapath import ldst_pkg::*; #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int LD_DEPTH = 4,
  parameter int ST_DEPTH = 4,
  localparam int LCW     = $clog2(LD_DEPTH + 1),
  localparam int SCW     = $clog2(ST_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  qStrobe_t       strb,
  input  logic [AW-1:0]  ldAddr,
  input  logic [AW-1:0]  stAddr,
  input  logic [DW-1:0]  pushData,
  input  logic [DW-1:0]  memRspData,
  output logic [DW-1:0]  popData,
  output logic [AW-1:0]  memReqAddr,
  output logic [DW-1:0]  memReqData,
  output logic [LCW-1:0] ldCount,
  output logic           ldEmpty,
  output logic           ldFull,
  output logic [SCW-1:0] sdCount,
  output logic           sdEmpty,
  output logic           sdFull,
  output logic [SCW-1:0] saCount,
  output logic           saEmpty,
  output logic           saFull
);
  logic [DW-1:0] sdHead;
  logic [AW-1:0] saHead;

  ldst_fifo #(.W(DW), .DEPTH(LD_DEPTH)) u_ldq (
    .clk(clk), .rstN(rstN), .push(strb.ldPush), .pop(strb.ldPop),
    .wrData(memRspData), .rdData(popData),
    .count(ldCount), .empty(ldEmpty), .full(ldFull));

  ldst_fifo #(.W(DW), .DEPTH(ST_DEPTH)) u_sdq (
    .clk(clk), .rstN(rstN), .push(strb.sdPush), .pop(strb.sdPop),
    .wrData(pushData), .rdData(sdHead),
    .count(sdCount), .empty(sdEmpty), .full(sdFull));

  ldst_fifo #(.W(AW), .DEPTH(ST_DEPTH)) u_saq (
    .clk(clk), .rstN(rstN), .push(strb.saPush), .pop(strb.saPop),
    .wrData(stAddr), .rdData(saHead),
    .count(saCount), .empty(saEmpty), .full(saFull));

  always_comb begin
    memReqAddr = strb.issueStore ? saHead : ldAddr;
    memReqData = strb.issueStore ? sdHead : '0;
  end
endmodule

// File: rtl/ldst_control.sv
`timescale 1ns/1ps
module ldst_control import ldst_pkg::*; #(
  parameter int LD_DEPTH = 4,
  parameter int ST_DEPTH = 4,
  localparam int LCW     = $clog2(LD_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           ldAddrValid,
  input  logic           stAddrValid,
  input  logic           popReq,
  input  logic           pushReq,
  input  logic           memReqReady,
  input  logic           memRspValid,
  input  logic [LCW-1:0] ldCount,
  input  logic           ldEmpty,
  input  logic           sdEmpty,
  input  logic           sdFull,
  input  logic           saEmpty,
  input  logic           saFull,
  output qStrobe_t       strb,
  output logic           ldAddrStall,
  output logic           stAddrStall,
  output logic           popStall,
  output logic           pushStall,
  output logic           memReqValid,
  output logic           memReqWrite,
  output logic           trap,
  output logic [LCW-1:0] outstanding
);
  logic [LCW:0] inFlight;
  logic credit, ldWant, loadAccept, storeReady, storeAccept;
  logic popDead, pushDead;

  assign inFlight    = {1'b0, outstanding} + {1'b0, ldCount};
  assign credit      = inFlight < (LCW + 1)'(LD_DEPTH);
  assign ldWant      = ldAddrValid && credit;
  assign loadAccept  = ldWant && memReqReady;
  assign storeReady  = !sdEmpty && !saEmpty;

  // Loads own the port whenever they can go; stores fill the gaps
  assign memReqValid = ldWant || storeReady;
  assign memReqWrite = !ldWant && storeReady;
  assign storeAccept = memReqWrite && memReqReady;

  assign ldAddrStall = ldAddrValid && !loadAccept;
  assign popStall    = popReq && ldEmpty;
  assign pushStall   = pushReq && sdFull;
  assign stAddrStall = stAddrValid && saFull;

  always_comb begin
    strb.ldPush     = memRspValid;
    strb.ldPop      = popReq && !ldEmpty;
    strb.sdPush     = pushReq && !sdFull;
    strb.sdPop      = storeAccept;
    strb.saPush     = stAddrValid && !saFull;
    strb.saPop      = storeAccept;
    strb.issueStore = memReqWrite;
  end

  // Stalls with nothing in flight that could ever release them
  assign popDead  = popReq && ldEmpty && (outstanding == '0) && !loadAccept;
  assign pushDead = pushReq && sdFull && saEmpty && !stAddrValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= '0;
      trap        <= 1'b0;
    end else begin
      case ({loadAccept, memRspValid})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: outstanding <= outstanding;
      endcase
      if (popDead || pushDead) trap <= 1'b1;
    end
  end
endmodule

// File: rtl/ldst_queue_unit.sv
`timescale 1ns/1ps
module ldst_queue_unit import ldst_pkg::*; #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int LD_DEPTH = 4,
  parameter int ST_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ldAddrValid,
  input  logic [AW-1:0] ldAddr,
  output logic          ldAddrStall,
  input  logic          stAddrValid,
  input  logic [AW-1:0] stAddr,
  output logic          stAddrStall,
  input  logic          popReq,
  output logic [DW-1:0] popData,
  output logic          popStall,
  input  logic          pushReq,
  input  logic [DW-1:0] pushData,
  output logic          pushStall,
  output logic          memReqValid,
  output logic          memReqWrite,
  output logic [AW-1:0] memReqAddr,
  output logic [DW-1:0] memReqData,
  input  logic          memReqReady,
  input  logic          memRspValid,
  input  logic [DW-1:0] memRspData,
  output logic          trap
);
  localparam int LCW = $clog2(LD_DEPTH + 1);
  localparam int SCW = $clog2(ST_DEPTH + 1);

  qStrobe_t       strb;
  logic [LCW-1:0] ldCount, outstanding;
  logic [SCW-1:0] sdCount, saCount;
  logic           ldEmpty, ldFull, sdEmpty, sdFull, saEmpty, saFull;

  ldst_control #(.LD_DEPTH(LD_DEPTH), .ST_DEPTH(ST_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ldAddrValid(ldAddrValid), .stAddrValid(stAddrValid),
    .popReq(popReq), .pushReq(pushReq),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .ldCount(ldCount), .ldEmpty(ldEmpty),
    .sdEmpty(sdEmpty), .sdFull(sdFull),
    .saEmpty(saEmpty), .saFull(saFull),
    .strb(strb),
    .ldAddrStall(ldAddrStall), .stAddrStall(stAddrStall),
    .popStall(popStall), .pushStall(pushStall),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .trap(trap), .outstanding(outstanding));

  ldst_datapath #(.AW(AW), .DW(DW), .LD_DEPTH(LD_DEPTH), .ST_DEPTH(ST_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ldAddr(ldAddr), .stAddr(stAddr), .pushData(pushData),
    .memRspData(memRspData), .popData(popData),
    .memReqAddr(memReqAddr), .memReqData(memReqData),
    .ldCount(ldCount), .ldEmpty(ldEmpty), .ldFull(ldFull),
    .sdCount(sdCount), .sdEmpty(sdEmpty), .sdFull(sdFull),
    .saCount(saCount), .saEmpty(saEmpty), .saFull(saFull));
endmodule

// File: rtl/ldst_checker.sv
`timescale 1ns/1ps
module ldst_checker #(
  parameter int LD_DEPTH = 4,
  parameter int ST_DEPTH = 4,
  localparam int LCW     = $clog2(LD_DEPTH + 1),
  localparam int SCW     = $clog2(ST_DEPTH + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           ldAddrValid,
  input logic           ldAddrStall,
  input logic           stAddrValid,
  input logic           stAddrStall,
  input logic           popReq,
  input logic           popStall,
  input logic           pushReq,
  input logic           pushStall,
  input logic           memReqValid,
  input logic           memReqWrite,
  input logic           memRspValid,
  input logic           trap,
  input logic [LCW-1:0] outstanding,
  input logic [LCW-1:0] ldCount,
  input logic [SCW-1:0] sdCount,
  input logic [SCW-1:0] saCount
);
  assert_credit_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, outstanding} + {1'b0, ldCount}) <= (LCW + 1)'(LD_DEPTH));

  assert_rsp_owned_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> outstanding != '0);

  assert_pop_empty_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && ldCount == '0) |-> popStall);

  assert_push_full_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && sdCount == SCW'(ST_DEPTH)) |-> pushStall);

  assert_store_heads_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (sdCount != '0 && saCount != '0));

  assert_load_priority_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ldAddrValid && !ldAddrStall) |-> (memReqValid && !memReqWrite));

  assert_trap_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    trap |=> trap);

  assert_pop_and_rsp_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && popReq && !popStall) |=> ldCount == $past(ldCount));

  assert_addr_full_stall_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stAddrValid && saCount == SCW'(ST_DEPTH)) |-> stAddrStall);
endmodule

bind ldst_queue_unit ldst_checker #(.LD_DEPTH(LD_DEPTH), .ST_DEPTH(ST_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN),
  .ldAddrValid(ldAddrValid), .ldAddrStall(ldAddrStall),
  .stAddrValid(stAddrValid), .stAddrStall(stAddrStall),
  .popReq(popReq), .popStall(popStall),
  .pushReq(pushReq), .pushStall(pushStall),
  .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .memRspValid(memRspValid), .trap(trap),
  .outstanding(outstanding), .ldCount(ldCount),
  .sdCount(sdCount), .saCount(saCount));

// File: tb/sim_ldst_queue_unit.sv
`timescale 1ns/1ps
module sim_ldst_queue_unit;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LDD = 4;
  localparam int STD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldAddrValid = 0, stAddrValid = 0, popReq = 0, pushReq = 0;
  logic memReqReady = 0, memRspValid = 0;
  logic [AW-1:0] ldAddr = '0, stAddr = '0;
  logic [DW-1:0] pushData = '0, memRspData = '0;
  logic ldAddrStall, stAddrStall, popStall, pushStall;
  logic memReqValid, memReqWrite, trap;
  logic [AW-1:0] memReqAddr;
  logic [DW-1:0] popData, memReqData;

  always #2.5 clk = ~clk;

  ldst_queue_unit #(.AW(AW), .DW(DW), .LD_DEPTH(LDD), .ST_DEPTH(STD)) u0 (
    .clk(clk), .rstN(rstN),
    .ldAddrValid(ldAddrValid), .ldAddr(ldAddr), .ldAddrStall(ldAddrStall),
    .stAddrValid(stAddrValid), .stAddr(stAddr), .stAddrStall(stAddrStall),
    .popReq(popReq), .popData(popData), .popStall(popStall),
    .pushReq(pushReq), .pushData(pushData), .pushStall(pushStall),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqData(memReqData),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .memRspData(memRspData), .trap(trap));

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  // reference model state
  int          mOut;
  logic [31:0] mLdQ[$];
  logic [31:0] pendAddr[$];
  int          pendDue[$];
  logic [31:0] mSd[$];
  logic [31:0] mSa[$];
  logic        mTrap;

  function automatic logic [31:0] memData(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h5A3C_96E1;
  endfunction

  function automatic bit chance(input int pct);
    return int'($urandom % 100) < pct;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clearModel();
    mOut = 0; mTrap = 0;
    mLdQ.delete(); pendAddr.delete(); pendDue.delete();
    mSd.delete(); mSa.delete();
  endtask

  task automatic idleInputs();
    ldAddrValid = 0; stAddrValid = 0; popReq = 0; pushReq = 0;
    memReqReady = 0; memRspValid = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; idleInputs();
    repeat (2) @(negedge clk);
    clearModel();
    rstN = 1;
  endtask

  // One cycle: drive at negedge, check combinational outputs, update model
  task automatic cycle(input bit ldV, input bit pop, input bit push,
                       input bit stV, input bit rdy, input bit rspOk);
    bit credit, ldWant, loadAcc, storeCand, expWrite, rspNow, popOk, storeAcc;
    logic [31:0] rspA;
    @(negedge clk);
    ldAddrValid = ldV; ldAddr = AW'($urandom);
    popReq = pop; pushReq = push; pushData = $urandom;
    stAddrValid = stV; stAddr = AW'($urandom);
    memReqReady = rdy;
    rspNow = rspOk && pendDue.size() > 0 && pendDue[0] <= cyc;
    memRspValid = rspNow;
    rspA = rspNow ? pendAddr[0] : 32'h0;
    memRspData = rspNow ? memData(rspA) : $urandom;
    #1;
    credit    = (mOut + mLdQ.size()) < LDD;
    ldWant    = ldV && credit;
    loadAcc   = ldWant && rdy;
    storeCand = mSd.size() > 0 && mSa.size() > 0;
    expWrite  = !ldWant && storeCand;
    popOk     = pop && mLdQ.size() > 0;

    check("R9 trap", {31'b0, trap}, {31'b0, mTrap});
    check(credit ? "R2 ldAddrStall" : "R3 ldAddrStall",
          {31'b0, ldAddrStall}, {31'b0, ldV && !loadAcc});
    check("R2 memReqValid", {31'b0, memReqValid}, {31'b0, ldWant || storeCand});
    check("R8 memReqWrite", {31'b0, memReqWrite}, {31'b0, expWrite});
    if (ldWant) check("R2 memReqAddr", {16'b0, memReqAddr}, {16'b0, ldAddr});
    if (expWrite) begin
      check("R7 store addr", {16'b0, memReqAddr}, mSa[0]);
      check("R7 store data", memReqData, mSd[0]);
    end
    check("R5 popStall", {31'b0, popStall}, {31'b0, pop && mLdQ.size() == 0});
    if (popOk) check(rspNow ? "R11 popData" : "R4 popData", popData, mLdQ[0]);
    check("R6 pushStall", {31'b0, pushStall}, {31'b0, push && mSd.size() == STD});
    check("R12 stAddrStall", {31'b0, stAddrStall}, {31'b0, stV && mSa.size() == STD});

    // model update, mirroring one clock edge
    if ((pop && mLdQ.size() == 0 && mOut == 0 && !loadAcc) ||
        (push && mSd.size() == STD && mSa.size() == 0 && !stV))
      mTrap = 1;
    storeAcc = expWrite && rdy;
    if (popOk) void'(mLdQ.pop_front());
    if (rspNow) begin
      mLdQ.push_back(memData(rspA));
      void'(pendAddr.pop_front()); void'(pendDue.pop_front());
      mOut--;
    end
    if (storeAcc) begin void'(mSd.pop_front()); void'(mSa.pop_front()); end
    if (push && mSd.size() < STD + (storeAcc ? 1 : 0) && !(mSd.size() + (storeAcc ? 1 : 0) == STD))
      mSd.push_back(pushData);
    if (stV && !(mSa.size() + (storeAcc ? 1 : 0) == STD))
      mSa.push_back({16'b0, stAddr});
    if (loadAcc) begin
      mOut++;
      pendAddr.push_back({16'b0, ldAddr});
      pendDue.push_back(cyc + 1 + int'($urandom % 4));
    end
    cyc++;
  endtask

  task automatic randomPhase(input int n, input int pL, input int pP, input int pW,
                             input int pA, input int pR, input int pS);
    for (int i = 0; i < n; i++) begin
      bit pop, push;
      pop  = chance(pP) && (mLdQ.size() > 0 || mOut > 0);
      push = chance(pW) && !(mSd.size() == STD && mSa.size() == 0);
      cycle(chance(pL), pop, push, chance(pA), chance(pR), chance(pS));
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 60; i++)
      cycle(0, mLdQ.size() > 0, 0, 0, 1, 1);
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    clearModel();
    doReset();
    #1;
    // R1: idle outputs after reset
    check("R1 ldAddrStall", {31'b0, ldAddrStall}, 32'h0);
    check("R1 popStall", {31'b0, popStall}, 32'h0);
    check("R1 pushStall", {31'b0, pushStall}, 32'h0);
    check("R1 stAddrStall", {31'b0, stAddrStall}, 32'h0);
    check("R1 memReqValid", {31'b0, memReqValid}, 32'h0);
    check("R1 trap", {31'b0, trap}, 32'h0);

    // R11 directed: pop and response in the same cycle
    cycle(1, 0, 0, 0, 1, 0);
    cycle(1, 0, 0, 0, 1, 1);
    cycle(0, 1, 0, 0, 1, 1);
    cycle(0, 1, 0, 0, 1, 1);
    drain();

    // R3 directed: four loads, no responses, fifth stalls
    for (int i = 0; i < 5; i++) cycle(1, 0, 0, 0, 1, 0);
    drain();

    // random phases: load pressure, store data full, store address full, mixed
    randomPhase(800, 85, 20, 30, 30, 90, 35);
    randomPhase(800, 20, 80, 80, 10, 60, 90);
    randomPhase(800, 10, 50, 10, 80, 30, 50);
    randomPhase(800, 50, 50, 50, 50, 50, 50);
    drain();
    for (int i = 0; i < 30; i++) cycle(0, 0, 0, 0, 1, 0);

    // R9: read of an empty queue with nothing outstanding
    cycle(0, mLdQ.size() == 0 && mOut == 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0);
    check("R9 trap set", {31'b0, trap}, 32'h1);
    doReset();
    #1;
    check("R10 trap cleared by reset", {31'b0, trap}, 32'h0);

    // R10: full store data queue, no address anywhere
    for (int i = 0; i < STD; i++) cycle(0, 0, 1, 0, 1, 0);
    cycle(0, 0, 1, 0, 1, 0);
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 1, 0);
    check("R10 trap held", {31'b0, trap}, 32'h1);
    doReset();
    #1;
    check("R10 trap cleared", {31'b0, trap}, 32'h0);

    finishRun();
  end
endmodule